// File: doc/BRIEF.md
# High-Start Oversampled Serial Byte Receiver

This block recovers bytes from an asynchronous serial line whose polarity is the reverse of the usual one. The line rests low. A frame opens with a high start bit, carries eight data bits with the least significant bit first, and ends with a low stop bit. The receiver clock runs at sixteen times the bit rate. One example is a 10 MHz clock for 625 kbit/s.

The input first passes through a synchronizer. A controller then qualifies a rising edge as a start bit, but only if the line stays high until the middle of that bit. It shifts in one data bit at the middle of each following bit period, and finally checks the stop level. The middle of the bit is found by a down-counting bit-time divider that is preset to 6 while the line is idle. A correct frame publishes its byte on a parallel output and raises a ready flag for one bit time. A frame with a bad stop bit is dropped, and the receiver then waits for the line to fall before it looks for a new start bit.

Top module: `frame_rx`

## Requirements
- R1: While a synchronous reset is applied, and at any point of a frame, `ready_o` is 0 on the following cycle, `data_o` is 0x00, and the controller returns to idle.
- R2: A frame of start level 1, data bits D0..D7 sent in that order, and stop level 0 (each bit held 16 clock cycles) makes `data_o` equal to the byte whose bit 0 is D0 and bit 7 is D7.
- R3: After a correctly framed byte, `ready_o` goes high exactly once and stays high for exactly 16 consecutive cycles.
- R4: A high level on the line that lasts 4 cycles or less is not taken as a start bit. No ready pulse follows, and `data_o` does not change.
- R5: When the level sampled in the stop slot is 1, the byte is dropped. `ready_o` stays 0 and `data_o` keeps its previous value.
- R6: After a dropped frame, a line that stays high never starts a new frame. Reception resumes only after the line has returned low, and the next correct frame is then received normally.
- R7: `data_o` changes only in the cycle in which `ready_o` rises, and holds its value through idle time and through rejected frames.
- R8: A line held low produces no ready pulse, whatever its duration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, 16 times the bit rate |
| rst_i | input | 1 | Synchronous reset, active high |
| ser_i | input | 1 | Serial line, idles low, start level 1, stop level 0 |
| data_o | output | 8 | Last correctly received byte |
| ready_o | output | 1 | High for one bit time after a correctly framed byte |

## Verification
On the last tick of a frame, one cycle serves two functions. The receiver must choose between shifting in a data bit and judging the stop level, and only the bit counter reaching zero decides which one happens. The bench provokes this case with frames in which D7 differs from the stop level: 0x80 with a good stop bit, and 0x7F with a bad one. A mistake here would either shift the stop level into the byte or judge D7 as the stop bit. The result is judged by the value on `data_o` and by the number of ready pulses and their width.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_DATA    = 3'd2,
        ST_READY   = 3'd3,
        ST_RECOVER = 3'd4
    } rx_state_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign chain_d[i] = d_i;
        end else begin : g_next
            assign chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
    parameter int PERIOD = 16,
    parameter int PRESET = 6
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    output logic tick_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] TOP  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] INIT = CW'(PRESET);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        if (load_i)              cnt_d = INIT;
        else if (cnt_q == '0)    cnt_d = TOP;
        else                     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= INIT;
        else       cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/bit_counter.sv
module bit_counter #(
    parameter int COUNT = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    input  logic dec_i,
    output logic zero_o
);
    localparam int CW = $clog2(COUNT + 1);
    localparam logic [CW-1:0] FULL = CW'(COUNT);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                   cnt_d = FULL;
        else if (dec_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= FULL;
        else       cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/shift_reg.sv
module shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             shift_i,
    input  logic             sin_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] sr_d;
    logic [WIDTH-1:0] sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_i) begin
            if (WIDTH > 1) sr_d = {sin_i, sr_q[WIDTH-1:1]};
            else           sr_d = sin_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sr_q <= '0;
        else       sr_q <= sr_d;
    end

    assign q_o = sr_q;
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
    parameter int DATA_W       = 8,
    parameter int OVERSAMPLE   = 16,
    parameter int PHASE_PRESET = 6,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ser_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o
);
    import frame_rx_pkg::*;

    typedef struct packed {
        rx_state_e         state;
        logic [DATA_W-1:0] data;
        logic              ready;
    } ctl_t;

    ctl_t d, q;

    logic              line_s;
    logic              tick;
    logic              bits_zero;
    logic              timer_load;
    logic              bits_load;
    logic              shift_en;
    logic [DATA_W-1:0] shift_q;
    rx_state_e         state_q;

    line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (ser_i),
        .q_o   (line_s)
    );

    bit_timer #(.PERIOD(OVERSAMPLE), .PRESET(PHASE_PRESET)) i_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (timer_load),
        .tick_o (tick)
    );

    bit_counter #(.COUNT(DATA_W)) i_bits (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (bits_load),
        .dec_i  (shift_en),
        .zero_o (bits_zero)
    );

    shift_reg #(.WIDTH(DATA_W)) i_shift (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (shift_en),
        .sin_i   (line_s),
        .q_o     (shift_q)
    );

    always_comb begin
        d          = q;
        timer_load = 1'b0;
        bits_load  = 1'b0;
        shift_en   = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                timer_load = 1'b1;
                bits_load  = 1'b1;
                if (line_s) d.state = ST_START;
            end
            ST_START: begin
                if (!line_s)   d.state = ST_IDLE;
                else if (tick) d.state = ST_DATA;
            end
            ST_DATA: begin
                if (tick) begin
                    if (!bits_zero) begin
                        shift_en = 1'b1;
                    end else if (!line_s) begin
                        d.state = ST_READY;
                        d.data  = shift_q;
                    end else begin
                        d.state = ST_RECOVER;
                    end
                end
            end
            ST_READY: begin
                if (tick) d.state = ST_IDLE;
            end
            ST_RECOVER: begin
                if (!line_s) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
        d.ready = (d.state == ST_READY);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q.state <= ST_IDLE;
            q.data  <= '0;
            q.ready <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_q = q.state;
    assign data_o  = q.data;
    assign ready_o = q.ready;
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    line_s,
    input logic [DATA_W-1:0]       data_o,
    input logic                    ready_o,
    input frame_rx_pkg::rx_state_e state_q
);
    import frame_rx_pkg::*;

    localparam int RW = $clog2(OVERSAMPLE) + 2;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)        run_q <= '0;
        else if (ready_o) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        rst_i |=> (!ready_o && data_o == '0 && state_q == ST_IDLE));

    assert_good_stop_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ready_o) |-> !$past(line_s));

    assert_ready_width_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ready_o) |-> (run_q == RW'(OVERSAMPLE)));

    assert_ready_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        run_q <= RW'(OVERSAMPLE));

    assert_short_pulse_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_START && !line_s) |=> (state_q == ST_IDLE));

    assert_recover_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RECOVER && line_s) |=> (state_q == ST_RECOVER));

    assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(data_o) |-> $rose(ready_o));
endmodule

bind frame_rx frame_rx_chk #(
    .DATA_W     (DATA_W),
    .OVERSAMPLE (OVERSAMPLE)
) i_frame_rx_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .line_s  (line_s),
    .data_o  (data_o),
    .ready_o (ready_o),
    .state_q (state_q)
);

// File: tb/test_frame_rx.sv
module test_frame_rx;
    localparam int BT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser = 1'b0;
    logic [7:0] data;
    logic       ready;

    int checks = 0;
    int errors = 0;

    int         pulses = 0;
    int         run = 0;
    int         last_width = 0;
    logic [7:0] cap_data = 8'h00;
    logic [7:0] last_good = 8'h00;

    // {byte, stop level, expected pulses}
    localparam logic [9:0] VEC [6] = '{
        {8'hA5, 1'b0, 1'b1},
        {8'h3C, 1'b1, 1'b0},
        {8'h80, 1'b0, 1'b1},
        {8'h00, 1'b0, 1'b1},
        {8'h7F, 1'b1, 1'b0},
        {8'hFF, 1'b0, 1'b1}
    };

    always #4 clk = ~clk;

    frame_rx i_frame_rx (
        .clk_i   (clk),
        .rst_i   (rst),
        .ser_i   (ser),
        .data_o  (data),
        .ready_o (ready)
    );

    always @(negedge clk) begin
        if (ready) begin
            if (run == 0) begin
                pulses   = pulses + 1;
                cap_data = data;
            end
            run = run + 1;
        end else begin
            if (run != 0) last_width = run;
            run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser = 1'b0;
        end
    endtask

    task automatic level(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser = v;
        end
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        level(1'b1, BT);
        for (int k = 0; k < 8; k++) level(b[k], BT);
        level(stop, BT);
    endtask

    task automatic clear_mon();
        pulses     = 0;
        last_width = 0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(ready == 1'b0, "R1 ready in reset", ready, 0);
        chk(data == 8'h00, "R1 data in reset", data, 0);
        @(negedge clk);
        rst = 1'b0;

        clear_mon();
        idle(200);
        chk(pulses == 0, "R8 idle low", pulses, 0);

        clear_mon();
        level(1'b1, 4);
        idle(60);
        chk(pulses == 0, "R4 short high pulse", pulses, 0);
        chk(data == last_good, "R4 data unchanged", data, last_good);

        for (int v = 0; v < 6; v++) begin
            clear_mon();
            send(VEC[v][9:2], VEC[v][1]);
            idle(40);
            if (VEC[v][0]) last_good = VEC[v][9:2];
            chk(pulses == int'(VEC[v][0]), VEC[v][0] ? "R3 pulse count" : "R5 no pulse", pulses, VEC[v][0]);
            chk(data == last_good, VEC[v][0] ? "R2 byte value" : "R7 data held", data, last_good);
            if (VEC[v][0]) begin
                chk(last_width == BT, "R3 pulse width", last_width, BT);
                chk(cap_data == last_good, "R7 data at ready rise", cap_data, last_good);
            end
        end

        clear_mon();
        send(8'h55, 1'b1);
        level(1'b1, 80);
        idle(40);
        chk(pulses == 0, "R6 no frame while high", pulses, 0);
        send(8'h96, 1'b0);
        idle(40);
        last_good = 8'h96;
        chk(pulses == 1, "R6 resumed pulse count", pulses, 1);
        chk(data == 8'h96, "R6 resumed byte", data, 8'h96);

        clear_mon();
        level(1'b1, BT);
        level(1'b1, 40);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(ready == 1'b0, "R1 ready after mid reset", ready, 0);
        chk(data == 8'h00, "R1 data after mid reset", data, 0);
        rst = 1'b0;
        ser = 1'b0;
        idle(40);
        clear_mon();
        send(8'h3B, 1'b0);
        idle(40);
        chk(data == 8'h3B, "R2 byte after reset", data, 8'h3B);
        chk(pulses == 1 && last_width == BT, "R3 after reset", last_width, BT);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule